// File: doc/BRIEF.md
# SPI Master With Odd-Divisor Serial Clock

This block is a single-channel SPI master that runs from a low-speed peripheral clock. A start strobe begins one transfer. The block then asserts an active-low chip-select, produces a serial clock burst, shifts a parallel transmit word out on MOSI, and gathers a receive word from MISO. The serial clock period comes from a divisor input, counted in peripheral-clock cycles.

The divisor may be even or odd. With an odd divisor the high and low phases cannot be equal. The high phase is then rounded down to whole cycles, and the low phase takes the remaining cycle.

The serial clock rests low between transfers. Data follows clock-phase-1 timing: each bit is launched on the rising edge and captured on the falling edge. Chip-select goes active two serial periods before the first rising edge. It returns high one low phase after the final falling edge. The received word and a one-cycle done pulse follow one clock later.

Top module: `spi_odd_master`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, mosi is 0, busy is 0, done is 0 and rx_data is 0.
- R2: A divisor below 4 behaves exactly as 4, and a divisor above 128 behaves exactly as 128.
- R3: With an even clamped divisor N, every sclk high phase and every low phase lasts N/2 clock cycles.
- R4: With an odd clamped divisor N, every sclk high phase lasts (N-1)/2 cycles and every low phase lasts (N+1)/2 cycles.
- R5: The first sclk rising edge comes exactly 2N cycles after cs_n falls.
- R6: tx_data is sent MSB first. mosi changes only with a sclk rising edge and holds steady while sclk is high, so the value present at each falling edge is the current bit.
- R7: miso is sampled at each sclk falling edge. The first sample becomes rx_data bit 7.
- R8: cs_n rises one low-phase length after the last (eighth) sclk falling edge, which is ceil(N/2) cycles.
- R9: done is a single-cycle pulse one cycle after cs_n rises. It carries valid rx_data, and busy is already 0 in that cycle.
- R10: A start while busy is 1 is ignored. The running transfer keeps its word and gives exactly eight falling edges, and no further transfer begins.
- R11: sclk is 0 whenever cs_n is 1.
- R12: The divisor is captured when a transfer is accepted. Changing div_in during a transfer has no effect on its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one transfer (taken when idle) |
| tx_data | input | 8 | Word to transmit, captured on start |
| div_in | input | 8 | Serial clock period in clock cycles |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse when rx_data is updated |
| rx_data | output | 8 | Last received word |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip-select |

## Verification
The bench builds the block with its default parameters: 8-bit words, an 8-bit divisor input and legal periods from 4 to 128. The 8-bit divisor input can carry values below the floor and above the ceiling, so the clamp region can be driven directly at the ports.

The runs cover the shortest even period, which has two-cycle phases, and odd periods, where the phase lengths differ. They also cover the longest even and odd periods. For every phase and for the lead and lag windows, the bench compares the measured length against its own arithmetic.

// File: rtl/spi_odd_pkg.sv
package spi_odd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HIGH,
    ST_LOW,
    ST_DONE
  } seq_state_t;

  // Limit a requested period to the legal window.
  function automatic int unsigned clamp_div(input int unsigned raw,
                                            input int unsigned lo,
                                            input int unsigned hi);
    if (raw < lo) return lo;
    if (raw > hi) return hi;
    return raw;
  endfunction

  // High phase: rounded down half of the period.
  function automatic int unsigned first_phase(input int unsigned n);
    return n >> 1;
  endfunction

  // Low phase: whatever is left of the period.
  function automatic int unsigned second_phase(input int unsigned n);
    return n - (n >> 1);
  endfunction

endpackage

// File: rtl/spi_div_latch.sv
module spi_div_latch
  import spi_odd_pkg::*;
#(
  parameter int unsigned DIV_W     = 8,
  parameter int unsigned DIV_MIN   = 4,
  parameter int unsigned DIV_MAX   = 128,
  parameter int unsigned LEAD_MULT = 2,
  parameter int unsigned LEN_W     = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] div_in,
  output logic [LEN_W-1:0] ph1_len,
  output logic [LEN_W-1:0] ph2_len,
  output logic [LEN_W-1:0] lead_len
);

  int unsigned n_c;

  always_comb begin
    n_c = clamp_div({{(32-DIV_W){1'b0}}, div_in}, DIV_MIN, DIV_MAX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph1_len  <= LEN_W'(first_phase(DIV_MIN));
      ph2_len  <= LEN_W'(second_phase(DIV_MIN));
      lead_len <= LEN_W'(LEAD_MULT * DIV_MIN);
    end else if (load) begin
      ph1_len  <= LEN_W'(first_phase(n_c));
      ph2_len  <= LEN_W'(second_phase(n_c));
      lead_len <= LEN_W'(LEAD_MULT * n_c);
    end
  end

endmodule

// File: rtl/spi_seq_fsm.sv
module spi_seq_fsm
  import spi_odd_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LEN_W  = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] ph1_len,
  input  logic [LEN_W-1:0] ph2_len,
  input  logic [LEN_W-1:0] lead_len,
  output logic             accept,
  output logic             ev_rise,
  output logic             ev_fall,
  output logic             ev_last,
  output logic             ev_finish,
  output logic             sclk,
  output logic             cs_n,
  output logic             busy,
  output logic             done
);

  localparam int unsigned BIT_W = $clog2(DATA_W + 1);

  seq_state_t       state;
  logic [LEN_W-1:0] cnt;
  logic [LEN_W-1:0] cur_len;
  logic [BIT_W-1:0] bit_cnt;
  logic             cnt_end;
  logic             all_bits;

  always_comb begin
    case (state)
      ST_LEAD: cur_len = lead_len;
      ST_HIGH: cur_len = ph1_len;
      ST_LOW:  cur_len = ph2_len;
      default: cur_len = LEN_W'(1);
    endcase
  end

  assign cnt_end   = (cnt == cur_len - LEN_W'(1));
  assign all_bits  = (bit_cnt == BIT_W'(DATA_W));
  assign accept    = (state == ST_IDLE) && start;
  assign ev_rise   = cnt_end && ((state == ST_LEAD) || ((state == ST_LOW) && !all_bits));
  assign ev_fall   = cnt_end && (state == ST_HIGH);
  assign ev_last   = cnt_end && (state == ST_LOW) && all_bits;
  assign ev_finish = (state == ST_DONE);
  assign busy      = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      bit_cnt <= '0;
      sclk    <= 1'b0;
      cs_n    <= 1'b1;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_LEAD;
            cnt     <= '0;
            bit_cnt <= '0;
            cs_n    <= 1'b0;
          end
        end
        ST_LEAD: begin
          if (cnt_end) begin
            state <= ST_HIGH;
            cnt   <= '0;
            sclk  <= 1'b1;
          end else begin
            cnt <= cnt + LEN_W'(1);
          end
        end
        ST_HIGH: begin
          if (cnt_end) begin
            state   <= ST_LOW;
            cnt     <= '0;
            sclk    <= 1'b0;
            bit_cnt <= bit_cnt + BIT_W'(1);
          end else begin
            cnt <= cnt + LEN_W'(1);
          end
        end
        ST_LOW: begin
          if (cnt_end) begin
            cnt <= '0;
            if (all_bits) begin
              state <= ST_DONE;
              cs_n  <= 1'b1;
            end else begin
              state <= ST_HIGH;
              sclk  <= 1'b1;
            end
          end else begin
            cnt <= cnt + LEN_W'(1);
          end
        end
        ST_DONE: begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              ev_rise,
  input  logic              ev_fall,
  input  logic              ev_finish,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_word
);

  logic [DATA_W-1:0] tx_sh;
  logic [DATA_W-1:0] rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh   <= '0;
      rx_sh   <= '0;
      mosi    <= 1'b0;
      rx_word <= '0;
    end else begin
      if (load) begin
        tx_sh <= tx_word;
      end else if (ev_rise) begin
        mosi  <= tx_sh[DATA_W-1];
        tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
      end
      if (ev_fall) begin
        rx_sh <= {rx_sh[DATA_W-2:0], miso};
      end
      if (ev_finish) begin
        rx_word <= rx_sh;
      end
    end
  end

endmodule

// File: rtl/spi_odd_master.sv
module spi_odd_master #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned DIV_W     = 8,
  parameter int unsigned DIV_MIN   = 4,
  parameter int unsigned DIV_MAX   = 128,
  parameter int unsigned LEAD_MULT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_data,
  input  logic [DIV_W-1:0]  div_in,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_data,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              cs_n
);

  localparam int unsigned LEN_W = $clog2(LEAD_MULT * DIV_MAX + 1);

  logic [LEN_W-1:0] ph1_len;
  logic [LEN_W-1:0] ph2_len;
  logic [LEN_W-1:0] lead_len;
  logic             accept;
  logic             ev_rise;
  logic             ev_fall;
  logic             ev_last;
  logic             ev_finish;

  spi_div_latch #(
    .DIV_W(DIV_W), .DIV_MIN(DIV_MIN), .DIV_MAX(DIV_MAX),
    .LEAD_MULT(LEAD_MULT), .LEN_W(LEN_W)
  ) u_div (
    .clk(clk), .rst_n(rst_n), .load(accept), .div_in(div_in),
    .ph1_len(ph1_len), .ph2_len(ph2_len), .lead_len(lead_len)
  );

  spi_seq_fsm #(
    .DATA_W(DATA_W), .LEN_W(LEN_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .ph1_len(ph1_len), .ph2_len(ph2_len), .lead_len(lead_len),
    .accept(accept), .ev_rise(ev_rise), .ev_fall(ev_fall),
    .ev_last(ev_last), .ev_finish(ev_finish),
    .sclk(sclk), .cs_n(cs_n), .busy(busy), .done(done)
  );

  spi_shifter #(
    .DATA_W(DATA_W)
  ) u_shift (
    .clk(clk), .rst_n(rst_n), .load(accept), .tx_word(tx_data),
    .ev_rise(ev_rise), .ev_fall(ev_fall), .ev_finish(ev_finish),
    .miso(miso), .mosi(mosi), .rx_word(rx_data)
  );

endmodule

// File: rtl/spi_odd_master_chk.sv
module spi_odd_master_chk #(
  parameter int unsigned DIV_W   = 8,
  parameter int unsigned DIV_MIN = 4,
  parameter int unsigned DIV_MAX = 128,
  parameter int unsigned LEN_W   = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [DIV_W-1:0] div_in,
  input logic             busy,
  input logic             done,
  input logic             sclk,
  input logic             mosi,
  input logic             cs_n,
  input logic             ev_last
);

  int unsigned      dv;
  int unsigned      lim;
  logic [LEN_W-1:0] cfg_h1;
  logic [LEN_W-1:0] hi_run;

  always_comb begin
    dv  = {{(32-DIV_W){1'b0}}, div_in};
    lim = (dv < DIV_MIN) ? DIV_MIN : ((dv > DIV_MAX) ? DIV_MAX : dv);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_h1 <= '0;
      hi_run <= '0;
    end else begin
      if (start && !busy) cfg_h1 <= LEN_W'(lim / 2);
      hi_run <= sclk ? hi_run + LEN_W'(1) : '0;
    end
  end

  // R11
  sclk_inside_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !cs_n);

  // R9
  done_after_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> done);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

  // R4
  high_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> (hi_run == cfg_h1));

  // R10
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $past(!busy));

  // R8
  last_edge_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_last |-> (!sclk && !cs_n));

endmodule

bind spi_odd_master spi_odd_master_chk #(
  .DIV_W(DIV_W), .DIV_MIN(DIV_MIN), .DIV_MAX(DIV_MAX), .LEN_W(LEN_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .div_in(div_in),
  .busy(busy), .done(done), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
  .ev_last(ev_last)
);

// File: tb/spi_odd_master_bench.sv
module spi_odd_master_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic [7:0] div_in = 8'd4;
  logic       busy;
  logic       done;
  logic [7:0] rx_data;
  logic       sclk;
  logic       mosi;
  logic       miso = 1'b0;
  logic       cs_n;

  always #10 clk = ~clk;

  spi_odd_master u_spi_odd_master (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_data(tx_data),
    .div_in(div_in), .busy(busy), .done(done), .rx_data(rx_data),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  typedef struct {
    logic [7:0] tx;
    logic [7:0] slave;
    int         n;
  } item_t;

  item_t exp_q[$];
  item_t cur;
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    ended = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int legal_n(input int d);
    int r;
    r = d;
    if (r > 128) r = 128;
    if (r < 4) r = 4;
    return r;
  endfunction

  // Monitor: times every edge seen at the pins against the queued item.
  int  cyc = 0;
  int  t_cs, t_rise, t_fall, t_csr;
  int  nrise, nfall;
  logic [7:0] mosi_acc;
  logic prev_sclk = 1'b0, prev_cs = 1'b1, prev_done = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (sclk && cs_n) chk(1'b0, "R11", int'(sclk), 0);
      if (prev_cs && !cs_n) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R10", 1, 0);
          cur = '{tx: 8'h00, slave: 8'h00, n: 4};
        end else begin
          cur = exp_q.pop_front();
        end
        t_cs = cyc; nrise = 0; nfall = 0; mosi_acc = 8'h00;
      end
      if (!prev_sclk && sclk) begin
        if (nrise == 0)
          chk(cyc - t_cs == 2 * cur.n, "R5", cyc - t_cs, 2 * cur.n);
        else
          chk(cyc - t_fall == (cur.n + 1) / 2, (cur.n % 2) ? "R4" : "R3",
              cyc - t_fall, (cur.n + 1) / 2);
        if (nrise < 8) miso = cur.slave[7 - nrise];
        nrise++;
        t_rise = cyc;
      end
      if (prev_sclk && !sclk) begin
        chk(cyc - t_rise == cur.n / 2, (cur.n % 2) ? "R4" : "R3",
            cyc - t_rise, cur.n / 2);
        mosi_acc = {mosi_acc[6:0], mosi};
        nfall++;
        t_fall = cyc;
      end
      if (!prev_cs && cs_n) begin
        chk(cyc - t_fall == cur.n - cur.n / 2, "R8", cyc - t_fall, cur.n - cur.n / 2);
        chk(nfall == 8, "R10", nfall, 8);
        chk(mosi_acc == cur.tx, "R6", int'(mosi_acc), int'(cur.tx));
        t_csr = cyc;
      end
      if (done) begin
        chk(cyc - t_csr == 1, "R9", cyc - t_csr, 1);
        chk(rx_data == cur.slave, "R7", int'(rx_data), int'(cur.slave));
        chk(!busy, "R9", int'(busy), 0);
      end
      if (prev_done && done) chk(1'b0, "R9", 1, 0);
      prev_sclk = sclk; prev_cs = cs_n; prev_done = done;
    end
  end

  // Driver: issues one transfer and pushes its expectation.
  task automatic xfer(input logic [7:0] tx, input logic [7:0] slv,
                      input int d, input bit poke);
    @(negedge clk);
    while (busy) @(negedge clk);
    tx_data = tx;
    div_in  = 8'(d);
    start   = 1'b1;
    exp_q.push_back('{tx: tx, slave: slv, n: legal_n(d)});
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R10 / R12: ignored start and divisor change mid-transfer
      repeat (3) @(negedge clk);
      tx_data = ~tx;
      div_in  = 8'd9;
      start   = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (40) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cs_n == 1'b1, "R1", int'(cs_n), 1);
    chk(sclk == 1'b0, "R1", int'(sclk), 0);
    chk(mosi == 1'b0, "R1", int'(mosi), 0);
    chk(busy == 1'b0, "R1", int'(busy), 0);
    chk(done == 1'b0, "R1", int'(done), 0);
    chk(rx_data == 8'h00, "R1", int'(rx_data), 0);
    xfer(8'hA5, 8'h3C, 4, 1'b0);    // R3 shortest even period
    xfer(8'h5A, 8'hC3, 5, 1'b0);    // R4 shortest odd period
    xfer(8'hF0, 8'h0F, 7, 1'b0);    // R4
    xfer(8'h81, 8'h7E, 10, 1'b1);   // R10, R12
    xfer(8'h00, 8'hFF, 2, 1'b0);    // R2 below floor
    xfer(8'hFF, 8'h00, 200, 1'b0);  // R2 above ceiling
    xfer(8'h6B, 8'h94, 127, 1'b0);  // R4 longest odd period
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R10", exp_q.size(), 0);
    chk(cs_n == 1'b1 && !busy, "R10", int'(busy), 0);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

endmodule